// File: doc/BRIEF.md
# Interlocked-Strobe Memory Target

This block is a small memory that answers on a clockless request/acknowledge bus. A bus master puts an address on the bus, pulls the chip-select and memory-request lines low and sets the read/write select. Only after those lines have settled does it pull its request strobe low. The target notices the strobe in its own clock domain through a two-flop synchronizer and performs the access in an internal RAM. It waits a programmable number of local clocks to model access latency, then pulls its acknowledge strobe low. On a read, valid data appear on the data bus together with the acknowledge. The acknowledge stays low until the target sees the request strobe go high again. The data bus is released when the acknowledge goes back high, and the master may then start its next cycle.

Every control line is active low. While chip select is high, or the memory-request line is high, the target neither reads nor writes, never acknowledges, and waits quietly for the strobe to go away. The controller has four states. IDLE waits for a strobe. BUSY counts down the latency. ACK holds the acknowledge. SKIP waits out a strobe that was not addressed to this target.

The transitions are as follows. IDLE goes to BUSY on a synchronized strobe when the target is selected; this is the detection clock, where a write is stored and a read is fetched. IDLE goes to SKIP on a synchronized strobe when the target is not selected. BUSY goes to ACK once the latency count is zero. ACK goes to IDLE when the synchronized strobe is high again. SKIP goes to IDLE on the same condition.

Top module: `hsm_async_mem_slave`

## Requirements
- R1: After reset, ack_stb_n is high, bus_oe is low, bus_dout is all zeros and the controller is in IDLE.
- R2: With cs_n and mem_req_n both low, the first local clock edge at which the synchronized request strobe is low starts an access. If req_stb_n falls between clock edges, ack_stb_n is low after exactly 4 + wait_cfg rising edges, for every wait_cfg from 0 to 15.
- R3: A read is selected by rd_wr_n = 1. In a read, bus_oe is high and bus_dout carries the word most recently written to the address for exactly as long as ack_stb_n is low.
- R4: Once asserted, ack_stb_n stays low while req_stb_n stays low. It returns high on the third rising edge after req_stb_n rises, and the target then accepts a new access.
- R5: Whenever a read is not being acknowledged, bus_oe is low and bus_dout is all zeros.
- R6: While cs_n is high, req_stb_n causes no acknowledge and no change to the memory, for either level of rd_wr_n.
- R7: While mem_req_n is high, req_stb_n causes no acknowledge and no change to the memory.
- R8: A write is selected by rd_wr_n = 0. It stores bus_din at addr, both as present on the detection clock. The write is still acknowledged after the same latency, but bus_oe stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock of the target |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Word address, stable before the strobe falls |
| cs_n | input | 1 | Active-low chip select |
| mem_req_n | input | 1 | Active-low memory request |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| req_stb_n | input | 1 | Active-low request strobe from the master, asynchronous |
| wait_cfg | input | CW | Latency in local clocks, 0 to 15 |
| bus_din | input | DW | Write data from the master |
| bus_dout | output | DW | Read data, zero when not driven |
| bus_oe | output | 1 | High while the target drives read data |
| ack_stb_n | output | 1 | Active-low acknowledge strobe to the master |

## Verification
The hardest situation to reach is a strobe that the master holds low well past the acknowledge. In that case the target must keep the acknowledge and data steady and must not begin a second access. The stimulus holds the strobe for extra clocks after every acknowledge and then counts edges until the release. Each latency from 0 to 15 is driven on both a write pass and a read pass over every address. Unselected strobes are then mixed in with both read/write levels, and the addresses are read back afterwards to show that the memory was not touched.

// File: rtl/hsm_pkg.sv
package hsm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_ACK  = 2'd2,
        ST_SKIP = 2'd3
    } hsm_state_e;
endpackage

// File: rtl/hsm_sync.sv
module hsm_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/hsm_wait_counter.sv
module hsm_wait_counter #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          run,
    output logic          zero
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   cnt <= '0;
        else if (load)                cnt <= load_val;
        else if (run && cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && $past(run) && $past(cnt) == '0) |-> cnt == '0); // R2
endmodule

// File: rtl/hsm_ram.sv
module hsm_ram #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        if (re) rdata     <= mem[addr];
    end
endmodule

// File: rtl/hsm_async_mem_slave.sv
module hsm_async_mem_slave
    import hsm_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 8,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          cs_n,
    input  logic          mem_req_n,
    input  logic          rd_wr_n,
    input  logic          req_stb_n,
    input  logic [CW-1:0] wait_cfg,
    input  logic [DW-1:0] bus_din,
    output logic [DW-1:0] bus_dout,
    output logic          bus_oe,
    output logic          ack_stb_n
);
    hsm_state_e    state, state_nx;
    logic          stb_sync_n;
    logic          stb_seen;
    logic          selected;
    logic          start;
    logic          lat_zero;
    logic          is_read;
    logic          ram_we;
    logic          ram_re;
    logic [DW-1:0] ram_q;

    hsm_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (req_stb_n),
        .q_sync  (stb_sync_n)
    );

    assign stb_seen = !stb_sync_n;
    assign selected = !cs_n && !mem_req_n;
    assign start    = (state == ST_IDLE) && stb_seen && selected;
    assign ram_we   = start && !rd_wr_n;
    assign ram_re   = start && rd_wr_n;

    hsm_wait_counter #(.CW(CW)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .load_val (wait_cfg),
        .run      (state == ST_BUSY),
        .zero     (lat_zero)
    );

    hsm_ram #(.AW(AW), .DW(DW)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .re    (ram_re),
        .addr  (addr),
        .wdata (bus_din),
        .rdata (ram_q)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            is_read <= 1'b0;
        end else begin
            state <= state_nx;
            if (start) is_read <= rd_wr_n;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (stb_seen) state_nx = selected ? ST_BUSY : ST_SKIP;
            ST_BUSY: if (lat_zero) state_nx = ST_ACK;
            ST_ACK:  if (!stb_seen) state_nx = ST_IDLE;
            ST_SKIP: if (!stb_seen) state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        ack_stb_n = 1'b1;
        bus_oe    = 1'b0;
        unique case (state)
            ST_ACK: begin
                ack_stb_n = 1'b0;
                bus_oe    = is_read;
            end
            ST_IDLE, ST_BUSY, ST_SKIP: ;
        endcase
    end

    assign bus_dout = bus_oe ? ram_q : '0;

    AST_ACK_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_stb_n) |-> stb_seen); // R2
    AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_stb_n && stb_seen) |=> !ack_stb_n); // R4
    AST_OE_ONLY_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> !ack_stb_n); // R5
    AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && $past(bus_oe)) |-> $stable(bus_dout)); // R3
    AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |-> (ack_stb_n && !bus_oe)); // R6
    AST_WRITE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (!cs_n && !mem_req_n && state_nx == ST_BUSY)); // R7
    AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_stb_n && !is_read) |-> !bus_oe); // R8
endmodule

// File: tb/tb_hsm_async_mem_slave.sv
module tb_hsm_async_mem_slave;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          cs_n = 1'b1;
    logic          mem_req_n = 1'b1;
    logic          rd_wr_n = 1'b1;
    logic          req_stb_n = 1'b1;
    logic [CW-1:0] wait_cfg = '0;
    logic [DW-1:0] bus_din = '0;
    logic [DW-1:0] bus_dout;
    logic          bus_oe;
    logic          ack_stb_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    hsm_async_mem_slave #(.AW(AW), .DW(DW), .CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .cs_n(cs_n),
        .mem_req_n(mem_req_n), .rd_wr_n(rd_wr_n), .req_stb_n(req_stb_n),
        .wait_cfg(wait_cfg), .bus_din(bus_din), .bus_dout(bus_dout),
        .bus_oe(bus_oe), .ack_stb_n(ack_stb_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pattern(input int a, input int pass);
        return DW'((a * 37 + 5 + pass * 101) & 255);
    endfunction

    // Selected cycle: checks latency, data, hold and release
    task automatic bus_cycle(input int a, input bit rd, input logic [DW-1:0] wd,
                             input int w, input logic [DW-1:0] exp_rd);
        int n;
        @(negedge clk);
        addr = AW'(a); cs_n = 1'b0; mem_req_n = 1'b0; rd_wr_n = rd;
        bus_din = wd; wait_cfg = CW'(w);
        @(negedge clk);
        req_stb_n = 1'b0;
        n = 0;
        while (1) begin
            @(negedge clk);
            n++;
            if (!ack_stb_n || n > 40) break;
            check("R5 idle oe", 32'(bus_oe), 32'd0);
        end
        check("R2 latency", 32'(n), 32'(4 + w));
        check(rd ? "R3 oe on read" : "R8 oe on write", 32'(bus_oe), 32'(rd));
        check(rd ? "R3 read data" : "R5 write dout", 32'(bus_dout), rd ? 32'(exp_rd) : 32'd0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R4 ack held", 32'(ack_stb_n), 32'd0);
        end
        req_stb_n = 1'b1;
        n = 0;
        while (1) begin
            @(negedge clk);
            n++;
            if (ack_stb_n || n > 40) break;
        end
        check("R4 release", 32'(n), 32'd3);
        check("R5 oe after", 32'(bus_oe), 32'd0);
        check("R5 dout after", 32'(bus_dout), 32'd0);
        cs_n = 1'b1; mem_req_n = 1'b1;
    endtask

    // Unselected strobe: no acknowledge at any time
    task automatic dead_cycle(input int a, input bit rd, input bit cs_hi, input logic [DW-1:0] wd);
        int bad;
        @(negedge clk);
        addr = AW'(a); cs_n = cs_hi; mem_req_n = !cs_hi; rd_wr_n = rd; bus_din = wd;
        wait_cfg = '0;
        @(negedge clk);
        req_stb_n = 1'b0;
        bad = 0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (!ack_stb_n || bus_oe) bad++;
        end
        check(cs_hi ? "R6 no ack" : "R7 no ack", 32'(bad), 32'd0);
        req_stb_n = 1'b1;
        repeat (4) @(negedge clk);
        cs_n = 1'b1; mem_req_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 ack", 32'(ack_stb_n), 32'd1);
        check("R1 oe", 32'(bus_oe), 32'd0);
        check("R1 dout", 32'(bus_dout), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 ack after release", 32'(ack_stb_n), 32'd1);
        for (int a = 0; a < 16; a++) bus_cycle(a, 1'b0, pattern(a, 0), a % 16, '0);          // R8
        for (int a = 0; a < 16; a++) bus_cycle(a, 1'b1, '0, 15 - a, pattern(a, 0));         // R3
        for (int a = 0; a < 16; a += 3) begin
            dead_cycle(a, 1'b0, 1'b1, 8'hEE);   // R6 write level
            dead_cycle(a, 1'b1, 1'b1, 8'hEE);   // R6 read level
            dead_cycle(a, 1'b0, 1'b0, 8'hDD);   // R7
        end
        for (int a = 0; a < 16; a++) bus_cycle(a, 1'b1, '0, a & 3, pattern(a, 0));          // R6 R7 unchanged
        for (int a = 0; a < 16; a++) bus_cycle(a, 1'b0, pattern(a, 1), 7, '0);
        for (int a = 15; a >= 0; a--) bus_cycle(a, 1'b1, '0, 0, pattern(a, 1));
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule